// File: doc/BRIEF.md
# Dual-Mode Pixel Output Formatter

This block sits after a video link decoder. On every input pixel clock it takes one 24-bit RGB pixel, a data-enable flag, horizontal and vertical sync, and three general control bits. It places them on an even-pixel bus and an odd-pixel bus for a flat panel. In single mode each pixel goes straight to the even bus. In dual mode two consecutive pixels of a line leave together, so the panel clock runs at half the pixel rate.

Alongside the data the block produces an output clock enable and an output clock level. Both either run freely, or are held low during blanking for panels that need a gated clock. The level's phase depends on which panel clock edge is meant to latch the data. An active-low driver-off input forces every output to zero except control bit 0 (the first control bit), which stays live so that it can drive an external power-control loop. A stagger option gives a copy of the even bus delayed by one pixel cycle, standing in for a skewed launch of the even half.

Top module: `pixel_pair_formatter`

## Requirements
- R1: With `dualMode` low, the pixel sampled at clock edge t appears on `evenBus` after edge t, with blue in bits 7:0, green in 15:8 and red in 23:16. `oddBus` is zero. `clkEn` is high after every edge unless gating applies.
- R2: With `dualMode` high, each pair is sampled at edges t (even slot) and t+1 (odd slot). After edge t+1 the even pixel appears on `evenBus` and the odd pixel on `oddBus`. `clkEn` is high only after the odd-slot edge, so it is never high in two consecutive cycles.
- R3: In dual mode, the first active pixel of every line (data enable newly high) always takes the even slot, whatever the slot phase was during blanking.
- R4: In dual mode, when a line has an odd pixel count, its last pixel leaves on `evenBus` with `oddBus` zero and `deOut` high.
- R5: `deOut`, `hsOut`, `vsOut` and `ctlOut` carry the values of the pixel placed on `evenBus`, with the same latency. In dual mode these are the values sampled in the even slot.
- R6: Both pixel buses are zero whenever `deOut` is low.
- R7: With `gateClk` high, `clkEn` and `outClk` are low whenever `deOut` is low. With `gateClk` low, `clkEn` keeps its cadence through blanking.
- R8: In dual mode `outClk` equals `launchFall` in the first cycle of each output word and its inverse in the second. So the latching edge (rising for `launchFall`=0, falling for 1) falls mid-word. In single mode `outClk` is low.
- R9: While `drvOnN` is low, every output except `ctlOut[0]` is zero and `drvEn` is low. `ctlOut[0]` keeps following its input with the normal latency.
- R10: With `dualMode` high and `stagN` low, `evenLate` is `evenBus` delayed by one clock. Otherwise `evenLate` equals `evenBus`.
- R11: After reset, every data, sync, control and clock output is zero before the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixIn | input | 24 | Decoded pixel, red 23:16, green 15:8, blue 7:0 |
| deIn | input | 1 | Active-video flag |
| hsIn | input | 1 | Horizontal sync in |
| vsIn | input | 1 | Vertical sync in |
| ctlIn | input | 3 | General control bits in |
| dualMode | input | 1 | 0: one pixel per output clock, 1: two |
| gateClk | input | 1 | 1: output clock held low in blanking |
| launchFall | input | 1 | 0: panel latches on rising edge, 1: on falling |
| stagN | input | 1 | Active-low stagger select (dual mode only) |
| drvOnN | input | 1 | Active-low output driver power-down |
| evenBus | output | 24 | Even (or only) pixel |
| oddBus | output | 24 | Odd pixel in dual mode |
| evenLate | output | 24 | Even bus, delayed one clock when staggered |
| deOut | output | 1 | Active-video flag, aligned |
| hsOut | output | 1 | Horizontal sync, aligned |
| vsOut | output | 1 | Vertical sync, aligned |
| ctlOut | output | 3 | Control bits, aligned; bit 0 never masked |
| clkEn | output | 1 | One pulse per output word |
| outClk | output | 1 | Panel clock level |
| drvEn | output | 1 | Enable for the masked output group |

## Verification
A wrong slot phase shows at the ports on the first pair of a line. Pixels land on the wrong bus, or an odd pixel shows up paired with blank data, on the first `clkEn` pulse after data enable rises. A stale hold register shows as sync or control values one pixel off from their data, visible in the same cycle as the pair. Gating or masking faults appear in the very first blanking or driver-off cycle, so a sweep over every mode combination with lines of length one to five covers each slot phase and line-end parity within a few dozen cycles per setting.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef struct packed {
    logic loadEven;    // dual mode: capture even-slot pixel and side band
    logic emitPair;    // dual mode: publish held even with current odd
    logic emitSingle;  // single mode: publish current pixel
  } fmtStrobe_t;
endpackage

// File: rtl/fmt_ctrl.sv
module fmt_ctrl
  import fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       deIn,
  input  logic       dualMode,
  output fmtStrobe_t strobe
);
  logic dePrev;
  logic phaseR;
  logic deRise;
  logic curPhase;

  assign deRise   = deIn & ~dePrev;
  assign curPhase = deRise ? 1'b0 : phaseR;   // line start forces even slot

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dePrev <= 1'b0;
      phaseR <= 1'b0;
    end else begin
      dePrev <= deIn;
      phaseR <= dualMode ? ~curPhase : 1'b0;
    end
  end

  always_comb begin
    strobe.emitSingle = ~dualMode;
    strobe.loadEven   = dualMode & ~curPhase;
    strobe.emitPair   = dualMode & curPhase;
  end

  // R2: an active even slot is always followed by its odd slot
  p_pair_follows_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEven && deIn) |=> (!dualMode || strobe.emitPair));

  // R3: the first active pixel of a line is taken in the even slot
  p_line_starts_even_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dualMode && deIn && !$past(deIn)) |-> strobe.loadEven);
endmodule

// File: rtl/fmt_datapath.sv
module fmt_datapath
  import fmt_pkg::*;
#(
  parameter int CH_BITS  = 8,
  parameter int CTL_BITS = 3,
  localparam int PIX_BITS = 3 * CH_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  fmtStrobe_t          strobe,
  input  logic [PIX_BITS-1:0] pixIn,
  input  logic                deIn,
  input  logic                hsIn,
  input  logic                vsIn,
  input  logic [CTL_BITS-1:0] ctlIn,
  input  logic                dualMode,
  input  logic                gateClk,
  input  logic                launchFall,
  input  logic                stagN,
  input  logic                drvOnN,
  output logic [PIX_BITS-1:0] evenQ,
  output logic [PIX_BITS-1:0] oddQ,
  output logic [PIX_BITS-1:0] lateQ,
  output logic                deQ,
  output logic                hsQ,
  output logic                vsQ,
  output logic [CTL_BITS-1:0] ctlQ,
  output logic                tickQ,
  output logic                clkQ,
  output logic                drvEnQ
);
  // even-slot hold stage
  logic [PIX_BITS-1:0] holdPix;
  logic                holdDe, holdHs, holdVs;
  logic [CTL_BITS-1:0] holdCtl;
  // output stage
  logic [PIX_BITS-1:0] evenR, oddR, evenDly;
  logic                deR, hsR, vsR, tickR, clkR;
  logic [CTL_BITS-1:0] ctlR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdPix <= '0;
      holdDe  <= 1'b0;
      holdHs  <= 1'b0;
      holdVs  <= 1'b0;
      holdCtl <= '0;
      evenR   <= '0;
      oddR    <= '0;
      evenDly <= '0;
      deR     <= 1'b0;
      hsR     <= 1'b0;
      vsR     <= 1'b0;
      ctlR    <= '0;
      tickR   <= 1'b0;
      clkR    <= 1'b0;
    end else begin
      if (strobe.loadEven) begin
        holdPix <= pixIn;
        holdDe  <= deIn;
        holdHs  <= hsIn;
        holdVs  <= vsIn;
        holdCtl <= ctlIn;
      end
      if (strobe.emitSingle) begin
        evenR <= deIn ? pixIn : '0;
        oddR  <= '0;
        deR   <= deIn;
        hsR   <= hsIn;
        vsR   <= vsIn;
        ctlR  <= ctlIn;
        tickR <= gateClk ? deIn : 1'b1;
        clkR  <= 1'b0;
      end else if (strobe.emitPair) begin
        evenR <= holdDe ? holdPix : '0;
        oddR  <= (holdDe && deIn) ? pixIn : '0;
        deR   <= holdDe;
        hsR   <= holdHs;
        vsR   <= holdVs;
        ctlR  <= holdCtl;
        tickR <= gateClk ? holdDe : 1'b1;
        clkR  <= (gateClk && !holdDe) ? 1'b0 : launchFall;
      end else begin
        tickR <= 1'b0;
        clkR  <= (gateClk && !deR) ? 1'b0 : ~launchFall;
      end
      evenDly <= evenR;
    end
  end

  // stagger copy and driver-off masking
  logic                stagOn;
  logic [CTL_BITS-1:0] ctlKeep;

  assign stagOn  = dualMode & ~stagN;
  assign ctlKeep = drvOnN ? '1 : CTL_BITS'(1);

  assign evenQ  = drvOnN ? evenR : '0;
  assign oddQ   = drvOnN ? oddR  : '0;
  assign lateQ  = drvOnN ? (stagOn ? evenDly : evenR) : '0;
  assign deQ    = drvOnN & deR;
  assign hsQ    = drvOnN & hsR;
  assign vsQ    = drvOnN & vsR;
  assign tickQ  = drvOnN & tickR;
  assign clkQ   = drvOnN & clkR;
  assign ctlQ   = ctlR & ctlKeep;
  assign drvEnQ = drvOnN;

  // R1: single mode never places data on the odd bus
  p_single_odd_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitSingle |=> (oddR == '0));

  // R6: pixel buses are blank whenever the aligned enable is low
  p_blank_buses_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !deR |-> (evenR == '0 && oddR == '0));

  // R7: gated clock stays low in blanking
  p_gated_clock_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (gateClk && !deR) |-> (!tickR && !clkR));

  // R2: in dual mode output words are at least two cycles apart
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dualMode && tickR) |=> (!tickR || !dualMode));
endmodule

// File: rtl/pixel_pair_formatter.sv
module pixel_pair_formatter
  import fmt_pkg::*;
#(
  parameter int CH_BITS  = 8,
  parameter int CTL_BITS = 3,
  localparam int PIX_BITS = 3 * CH_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PIX_BITS-1:0] pixIn,
  input  logic                deIn,
  input  logic                hsIn,
  input  logic                vsIn,
  input  logic [CTL_BITS-1:0] ctlIn,
  input  logic                dualMode,
  input  logic                gateClk,
  input  logic                launchFall,
  input  logic                stagN,
  input  logic                drvOnN,
  output logic [PIX_BITS-1:0] evenBus,
  output logic [PIX_BITS-1:0] oddBus,
  output logic [PIX_BITS-1:0] evenLate,
  output logic                deOut,
  output logic                hsOut,
  output logic                vsOut,
  output logic [CTL_BITS-1:0] ctlOut,
  output logic                clkEn,
  output logic                outClk,
  output logic                drvEn
);
  fmtStrobe_t strobe;

  fmt_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .deIn     (deIn),
    .dualMode (dualMode),
    .strobe   (strobe)
  );

  fmt_datapath #(
    .CH_BITS  (CH_BITS),
    .CTL_BITS (CTL_BITS)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pixIn      (pixIn),
    .deIn       (deIn),
    .hsIn       (hsIn),
    .vsIn       (vsIn),
    .ctlIn      (ctlIn),
    .dualMode   (dualMode),
    .gateClk    (gateClk),
    .launchFall (launchFall),
    .stagN      (stagN),
    .drvOnN     (drvOnN),
    .evenQ      (evenBus),
    .oddQ       (oddBus),
    .lateQ      (evenLate),
    .deQ        (deOut),
    .hsQ        (hsOut),
    .vsQ        (vsOut),
    .ctlQ       (ctlOut),
    .tickQ      (clkEn),
    .clkQ       (outClk),
    .drvEnQ     (drvEn)
  );
endmodule

// File: tb/test_pixel_pair_formatter.sv
module test_pixel_pair_formatter;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 90;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] pixIn = '0;
  logic        deIn = 1'b0, hsIn = 1'b0, vsIn = 1'b0;
  logic [2:0]  ctlIn = '0;
  logic        dualMode = 1'b0, gateClk = 1'b0, launchFall = 1'b0;
  logic        stagN = 1'b1, drvOnN = 1'b1;
  logic [23:0] evenBus, oddBus, evenLate;
  logic        deOut, hsOut, vsOut, clkEn, outClk, drvEn;
  logic [2:0]  ctlOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_pair_formatter i_pixel_pair_formatter (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .deIn(deIn), .hsIn(hsIn),
    .vsIn(vsIn), .ctlIn(ctlIn), .dualMode(dualMode), .gateClk(gateClk),
    .launchFall(launchFall), .stagN(stagN), .drvOnN(drvOnN),
    .evenBus(evenBus), .oddBus(oddBus), .evenLate(evenLate),
    .deOut(deOut), .hsOut(hsOut), .vsOut(vsOut), .ctlOut(ctlOut),
    .clkEn(clkEn), .outClk(outClk), .drvEn(drvEn)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic runCfg(input int cfg);
    // bench-side record of the spec behaviour
    logic        pDe, pHs, pVs;
    logic [23:0] pPix;
    logic [2:0]  pCtl;
    logic        phaseReg, pRise;
    logic [23:0] eEven, eOdd, lastEven;
    logic        eDe, eHs, eVs, eTick, eClk;
    logic [2:0]  eCtl;
    int          pos, curLen, blankLeft;
    logic        dm, gt, lf, sg;
    dm = cfg[0]; gt = cfg[1]; lf = cfg[2]; sg = cfg[3];

    @(negedge clk);
    rstN = 1'b0; dualMode = dm; gateClk = gt; launchFall = lf; stagN = sg;
    drvOnN = 1'b1; deIn = 1'b0; pixIn = '0; hsIn = 1'b0; vsIn = 1'b0; ctlIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: reset state, before any edge after release
    chk("R11", "evenBus", 32'(evenBus), 32'd0);
    chk("R11", "oddBus", 32'(oddBus), 32'd0);
    chk("R11", "sync/de", 32'({deOut, hsOut, vsOut, ctlOut}), 32'd0);
    chk("R11", "clocks", 32'({clkEn, outClk}), 32'd0);

    pDe = 0; pHs = 0; pVs = 0; pPix = '0; pCtl = '0; phaseReg = 0; pRise = 0;
    eEven = '0; eOdd = '0; eDe = 0; eHs = 0; eVs = 0; eCtl = '0; eTick = 0; eClk = 0;
    pos = 0; curLen = 1; blankLeft = 2;

    for (int n = 0; n < RUN_CYCLES; n++) begin
      logic        cDe, cHs, cVs, rise, ph, off;
      logic [23:0] cPix;
      logic [2:0]  cCtl;
      string       pixTag;
      if (blankLeft > 0) begin
        cDe = 1'b0; blankLeft--;
      end else begin
        cDe = 1'b1; pos++;
        if (pos == curLen) begin
          blankLeft = 3; curLen = (curLen % 5) + 1; pos = 0;
        end
      end
      cPix = {8'(cfg * 16 + n), 8'(n * 3 + 1), 8'(n ^ 8'h5A)};
      cHs  = (n % 7) < 2;
      cVs  = (n % 13) == 0;
      cCtl = 3'(n) ^ 3'(cfg);
      off  = (n >= 30 && n < 38);
      pixIn = cPix; deIn = cDe; hsIn = cHs; vsIn = cVs; ctlIn = cCtl;
      drvOnN = ~off;
      @(posedge clk);
      @(negedge clk);

      lastEven = eEven;
      rise = cDe && !pDe;
      pixTag = dm ? "R2" : "R1";
      if (!dm) begin
        eEven = cDe ? cPix : '0; eOdd = '0;
        eDe = cDe; eHs = cHs; eVs = cVs; eCtl = cCtl;
        eTick = gt ? cDe : 1'b1; eClk = 1'b0;
        ph = 1'b0;
      end else begin
        ph = rise ? 1'b0 : phaseReg;
        phaseReg = ~ph;
        if (ph) begin
          eEven = pDe ? pPix : '0;
          eOdd  = (pDe && cDe) ? cPix : '0;
          eDe = pDe; eHs = pHs; eVs = pVs; eCtl = pCtl;
          eTick = gt ? pDe : 1'b1;
          eClk  = (gt && !pDe) ? 1'b0 : lf;
          if (pDe && !cDe) pixTag = "R4";       // odd-count line end
          else if (pRise) pixTag = "R3";        // first pair of a line
        end else begin
          eTick = 1'b0;
          eClk  = (gt && !eDe) ? 1'b0 : ~lf;
        end
      end
      if (!eDe) pixTag = "R6";
      if (off) pixTag = "R9";

      chk(pixTag, "evenBus", 32'(evenBus), off ? 32'd0 : 32'(eEven));
      chk(pixTag, "oddBus", 32'(oddBus), off ? 32'd0 : 32'(eOdd));
      chk(off ? "R9" : "R5", "deOut", 32'(deOut), off ? 32'd0 : 32'(eDe));
      chk(off ? "R9" : "R5", "hsOut", 32'(hsOut), off ? 32'd0 : 32'(eHs));
      chk(off ? "R9" : "R5", "vsOut", 32'(vsOut), off ? 32'd0 : 32'(eVs));
      chk(off ? "R9" : "R5", "ctlOut", 32'(ctlOut), off ? 32'(eCtl[0]) : 32'(eCtl));
      chk(off ? "R9" : (gt && !eDe) ? "R7" : (dm ? "R2" : "R1"), "clkEn",
          32'(clkEn), off ? 32'd0 : 32'(eTick));
      chk(off ? "R9" : (gt && !eDe) ? "R7" : "R8", "outClk",
          32'(outClk), off ? 32'd0 : 32'(eClk));
      chk(off ? "R9" : "R10", "evenLate", 32'(evenLate),
          off ? 32'd0 : ((dm && !sg) ? 32'(lastEven) : 32'(eEven)));
      chk("R9", "drvEn", 32'(drvEn), off ? 32'd0 : 32'd1);

      if (dm && !ph) pRise = rise;
      pDe = cDe; pHs = cHs; pVs = cVs; pPix = cPix; pCtl = cCtl;
    end
  endtask

  initial begin
    for (int cfg = 0; cfg < 16; cfg++) runCfg(cfg);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule